// File: doc/BRIEF.md
# Slot EEPROM Command Register Bridge

This block sits on a 16-bit host register bus and gives software a way to read the identification EEPROMs of up to three plug-in daughter-card slots. One register reports which slots hold a card. When software writes to that same register, the value is kept as a slot-select code, and only a small set of fixed codes picks a slot.

A second register takes an EEPROM command as two posted 16-bit writes. The first write carries the READ opcode with a 6-bit byte offset in its low bits. The second write is a filler word. Once both words have arrived, a one-shot read is armed. The next read of that register returns two consecutive bytes from the selected slot's image and disarms the command. An empty slot, an unknown select code or an unarmed read returns all ones.

Each slot's EEPROM is modelled as a 64-byte image plus a present flag. Both are supplied as input vectors. Read data is registered and appears one clock after the read strobe.

Top module: `slot_eeprom_bridge`

## Requirements
- R1: A read of offset 0x12 returns 0xFFFF, except that bit k (k = 0, 1, 2) is 0 when slot_present[k] is 1. Presence is active low in this register.
- R2: A write to offset 0x12 stores all 16 data bits as the select code. Code 0x1700 picks slot 0, 0x1D00 picks slot 1 and 0x3500 picks slot 2. Any other code picks no slot.
- R3: Writes to offset 0x42 fill a two-word command buffer in order. The command is armed only after the second word, and the word position then returns to the first word.
- R4: The byte offset is the low 6 bits of the first command word; the upper bits are ignored. An armed read of 0x42 returns the image byte at the offset in bits 15:8 and the byte at offset+1 in bits 7:0. Byte b of slot s is slot_image[(s*64+b)*8 +: 8].
- R5: A read of 0x42 disarms the command, so a second read with no new command returns 0xFFFF.
- R6: A read of 0x42 returns 0xFFFF when no command is armed, when the select code picks no slot, or when the selected slot is not present.
- R7: For offset 63, the low byte comes from offset 0 of the same image.
- R8: bus_rdata takes the read result on the clock edge that samples bus_rd, and it holds that value on every edge where bus_rd is low.
- R9: Writes to any address other than 0x12 and 0x42 change no state. Reads of any other address return 0xFFFF.
- R10: After reset, bus_rdata is 0xFFFF, no command is armed, the word position is 0 and the select code is 0, which picks no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| slot_present | input | 3 | Card with EEPROM present, one bit per slot |
| slot_image | input | 3*IMG_BYTES*8 | Concatenated byte images of the three slots |

## Verification
The bench builds the block with its default parameters: an 8-bit address and 64-byte images. This makes offset 63 and its wrap to byte 0 a reachable case. Each slot gets a distinct computed byte pattern, so a swapped slot, a swapped byte order or a missing wrap produces a visibly different word. Presence patterns are changed between reads, which exposes both the active-low presence bits and the empty-slot path.

// File: rtl/seb_pkg.sv
// Package: shared constants for the slot EEPROM bridge.
// Assumes a 16-bit register bus and exactly three slots with fixed select codes.
package seb_pkg;
    localparam int DATA_W = 16;
    localparam int NSLOT  = 3;
    localparam logic [7:0] PRES_OFF = 8'h12;
    localparam logic [7:0] CMD_OFF  = 8'h42;
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    // Select code that picks slot idx
    function automatic logic [DATA_W-1:0] slot_code(input int idx);
        case (idx)
            0:       slot_code = 16'h1700;
            1:       slot_code = 16'h1D00;
            default: slot_code = 16'h3500;
        endcase
    endfunction
endpackage

// File: rtl/seb_slot_decode.sv
// Module: turns the stored select code into a one-hot slot hit vector.
// Assumes codes from seb_pkg are distinct; unknown codes give all zeros.
module seb_slot_decode
    import seb_pkg::*;
(
    input  logic [DATA_W-1:0] sel_code,
    output logic [NSLOT-1:0]  slot_hit
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
        // Compare against the code of slot s
        assign slot_hit[s] = (sel_code == slot_code(s));
    end
endmodule

// File: rtl/seb_cmd_buf.sv
// Module: collects the two-word command and holds the armed flag.
// Assumes a read strobe and a write in the same cycle are allowed; arming wins.
module seb_cmd_buf
    import seb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd_word0,
    output logic              cmd_valid
);
    logic pos_q;

    // Word position, first word capture and arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q     <= 1'b0;
            cmd_word0 <= '0;
            cmd_valid <= 1'b0;
        end else begin
            if (cmd_rd)
                cmd_valid <= 1'b0;
            if (cmd_wr) begin
                if (!pos_q) begin
                    cmd_word0 <= wdata;
                    pos_q     <= 1'b1;
                end else begin
                    pos_q     <= 1'b0;
                    cmd_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/seb_image_read.sv
// Module: fetches two consecutive bytes from the hit slot's image.
// Assumes slot_hit is one-hot or zero; offset+1 wraps inside the image.
module seb_image_read
    import seb_pkg::*;
#(
    parameter int IMG_BYTES = 64,
    localparam int OFF_W = $clog2(IMG_BYTES)
) (
    input  logic [NSLOT-1:0]           slot_hit,
    input  logic [NSLOT-1:0]           slot_present,
    input  logic [NSLOT*IMG_BYTES*8-1:0] slot_image,
    input  logic [OFF_W-1:0]           offset,
    output logic [DATA_W-1:0]          word,
    output logic                       word_ok
);
    logic [OFF_W-1:0] off_nx;
    logic [NSLOT-1:0][DATA_W-1:0] per_slot;

    // Next offset with natural wrap
    assign off_nx = offset + 1'b1;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Byte pair of slot s
        assign per_slot[s] = {slot_image[(s*IMG_BYTES + int'(offset))*8 +: 8],
                              slot_image[(s*IMG_BYTES + int'(off_nx))*8 +: 8]};
    end

    // Merge the hit slot and decide whether it is usable
    always_comb begin
        word    = '0;
        word_ok = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (slot_hit[s]) begin
                word    = word | per_slot[s];
                word_ok = word_ok | slot_present[s];
            end
        end
    end
endmodule

// File: rtl/slot_eeprom_bridge.sv
// Module: top of the slot EEPROM register bridge.
// Assumes single-cycle bus strobes; read data is registered one clock late.
module slot_eeprom_bridge
    import seb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int IMG_BYTES = 64,
    localparam int OFF_W    = $clog2(IMG_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NSLOT-1:0]           slot_present,
    input  logic [NSLOT*IMG_BYTES*8-1:0] slot_image
);
    logic              hit_pres, hit_cmd;
    logic [DATA_W-1:0] sel_q;
    logic [NSLOT-1:0]  slot_hit;
    logic [DATA_W-1:0] cmd_word0;
    logic              cmd_valid;
    logic [DATA_W-1:0] img_word;
    logic              img_ok;
    logic [DATA_W-1:0] pres_word;
    logic [DATA_W-1:0] rd_next;

    // Address decode
    assign hit_pres = (bus_addr == ADDR_W'(PRES_OFF));
    assign hit_cmd  = (bus_addr == ADDR_W'(CMD_OFF));

    // Select code register
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_wr && hit_pres)
            sel_q <= bus_wdata;
    end

    seb_slot_decode i_dec (
        .sel_code (sel_q),
        .slot_hit (slot_hit)
    );

    seb_cmd_buf i_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (bus_wr && hit_cmd),
        .cmd_rd    (bus_rd && hit_cmd),
        .wdata     (bus_wdata),
        .cmd_word0 (cmd_word0),
        .cmd_valid (cmd_valid)
    );

    seb_image_read #(.IMG_BYTES(IMG_BYTES)) i_img (
        .slot_hit     (slot_hit),
        .slot_present (slot_present),
        .slot_image   (slot_image),
        .offset       (cmd_word0[OFF_W-1:0]),
        .word         (img_word),
        .word_ok      (img_ok)
    );

    // Active-low presence word
    always_comb begin
        pres_word = ALL_ONES;
        pres_word[NSLOT-1:0] = ~slot_present;
    end

    // Read data selection
    always_comb begin
        if (hit_pres)
            rd_next = pres_word;
        else if (hit_cmd && cmd_valid && img_ok)
            rd_next = img_word;
        else
            rd_next = ALL_ONES;
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= ALL_ONES;
        else if (bus_rd)
            bus_rdata <= rd_next;
    end
endmodule

// File: rtl/seb_checker.sv
// Module: property checks for slot_eeprom_bridge, attached by bind.
// Assumes it observes the top ports and the armed flag.
module seb_checker
    import seb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NSLOT-1:0]  slot_present,
    input logic              cmd_valid
);
    logic is_pres, is_cmd;
    assign is_pres = (bus_addr == ADDR_W'(PRES_OFF));
    assign is_cmd  = (bus_addr == ADDR_W'(CMD_OFF));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    assert_other_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !is_pres && !is_cmd) |=> (bus_rdata == ALL_ONES));

    assert_presence_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_pres) |=> (bus_rdata[DATA_W-1:NSLOT] == '1 &&
                                 bus_rdata[NSLOT-1:0] == ~$past(slot_present)));

    assert_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_cmd && !cmd_valid) |=> (bus_rdata == ALL_ONES));

    assert_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_cmd && !bus_wr && cmd_valid) |=> !cmd_valid);
endmodule

bind slot_eeprom_bridge seb_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .slot_present (slot_present),
    .cmd_valid    (cmd_valid)
);

// File: tb/test_slot_eeprom_bridge.sv
// Bench: scoreboard test for slot_eeprom_bridge, 50 MHz clock.
module test_slot_eeprom_bridge;
    localparam int IMG = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  slot_present = 3'b000;
    logic [3*IMG*8-1:0] slot_image;

    typedef struct { logic [15:0] exp; string tag; } item_t;
    item_t sbq[$];
    int n_checks = 0;
    int n_fail = 0;
    logic rd_q = 1'b0;

    always #10 clk = ~clk;

    slot_eeprom_bridge i_slot_eeprom_bridge (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slot_present(slot_present), .slot_image(slot_image)
    );

    function automatic logic [7:0] img_byte(input int s, input int b);
        return 8'((s * 77 + b * 5 + 3) & 255);
    endfunction

    initial begin
        for (int s = 0; s < 3; s++)
            for (int b = 0; b < IMG; b++)
                slot_image[(s*IMG+b)*8 +: 8] = img_byte(s, b);
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [15:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: note which edges sampled a read strobe
    always @(posedge clk) rd_q <= bus_rd;

    // Monitor: compare each read result against the scoreboard
    always @(negedge clk) begin
        if (rd_q) begin
            if (sbq.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R8: unexpected read result %h expected none", bus_rdata);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_rdata, 16'hFFFF, "R10 reset rdata");
        // R6 / R10: nothing armed after reset
        bus_read(8'h42, 16'hFFFF, "R10 R6 unarmed after reset");
        // R1 presence patterns
        slot_present = 3'b101;
        bus_read(8'h12, 16'hFFFA, "R1 presence 101");
        slot_present = 3'b010;
        bus_read(8'h12, 16'hFFFD, "R1 presence 010");
        slot_present = 3'b111;
        // R10: select code 0 picks no slot
        bus_write(8'h42, 16'h0185);
        bus_write(8'h42, 16'h0000);
        bus_read(8'h42, 16'hFFFF, "R10 select none after reset");
        // R2 R3 R4: slot 0, offset 5
        bus_write(8'h12, 16'h1700);
        bus_write(8'h42, 16'h0185);
        bus_read(8'h42, 16'hFFFF, "R3 one word does not arm");
        bus_write(8'h42, 16'h0000);
        bus_read(8'h42, {img_byte(0,5), img_byte(0,6)}, "R4 slot0 offset5");
        bus_read(8'h42, 16'hFFFF, "R5 second read disarmed");
        // R8: output holds while idle
        held = bus_rdata;
        repeat (3) @(negedge clk);
        check(bus_rdata, held, "R8 hold while idle");
        // R2 R7: slot 1, offset 63 wraps
        bus_write(8'h12, 16'h1D00);
        bus_write(8'h42, 16'h01BF);
        bus_write(8'h42, 16'h0000);
        bus_read(8'h42, {img_byte(1,63), img_byte(1,0)}, "R7 slot1 wrap");
        // R4: upper bits of first word ignored
        bus_write(8'h12, 16'h3500);
        bus_write(8'h42, 16'hFFD4);
        bus_write(8'h42, 16'h0000);
        bus_read(8'h42, {img_byte(2,20), img_byte(2,21)}, "R4 R2 slot2 high bits");
        // R6: empty slot
        slot_present = 3'b011;
        bus_write(8'h42, 16'h0182);
        bus_write(8'h42, 16'h0000);
        bus_read(8'h42, 16'hFFFF, "R6 empty slot");
        // R6 R2: unknown code
        slot_present = 3'b111;
        bus_write(8'h12, 16'h1701);
        bus_write(8'h42, 16'h0182);
        bus_write(8'h42, 16'h0000);
        bus_read(8'h42, 16'hFFFF, "R6 R2 unknown code");
        // R9: other addresses
        bus_write(8'h12, 16'h1700);
        bus_write(8'h13, 16'h3500);
        bus_write(8'h40, 16'h0000);
        bus_write(8'h20, 16'h1234);
        bus_read(8'h20, 16'hFFFF, "R9 other read");
        bus_write(8'h42, 16'h0190);
        bus_write(8'h42, 16'h0000);
        bus_read(8'h42, {img_byte(0,16), img_byte(0,17)}, "R9 stray writes ignored");
        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R8: got %0d pending expected 0", sbq.size());
        end
        finish_run();
    end
endmodule